// File: doc/BRIEF.md
# Indirect-Access Memory Controller Register File

This block holds the configuration and status registers of a four-bank SDRAM controller. The processor cannot address these registers directly. It uses two ports on its device control register bus. It first writes a register index to the index port. It then reads or writes the selected register through the data port. Each register applies its own write mask. The two error-status registers are cleared by writing ones to them. Status bits follow edges on the enable and self-refresh control bits of the configuration register. A level interrupt stays high while the ECC error status register holds a non-zero value.

The controller core reports bus errors on two set-vectors, and these bits are ORed into the error-status registers. Every access takes one clock cycle. Read data is registered and appears one cycle after the read strobe.

Top module: `memctl_cfg_regs`

## Requirements
- R1: A write to bus port 0x010 stores the full 32-bit register index. A read of port 0x010 returns that index. A read of any port other than 0x010 or 0x011 returns zero.
- R2: After reset, a data-port read returns the following values. Config (index 0x20) reads 0x00800000. Refresh timer (0x30) reads 0x05F00000. Idle timer (0x34) reads 0x07C00000. Error status 0 (0x00), error status 1 (0x08), error address (0x10), status (0x24), bank configs (0x40, 0x44, 0x48, 0x4C), ECC config (0x94) and ECC status (0x98) read zero.
- R3: A data-port read of the timing index 0x80, or of any index not listed in R2, returns 0xFFFFFFFF. Writes to those indices, and to the read-only status index 0x24, change no readable register.
- R4: Writing a value to index 0x00 or 0x08 clears every stored bit that is 1 in the value. Bits on the matching error-set input are ORed in on the same edge, and a set bit wins over a clear in the same cycle.
- R5: A config write stores the data ANDed with 0xFFE00000. If config bit 31 goes from 0 to 1, status bit 31 clears. If it goes from 1 to 0, status bit 31 sets.
- R6: If config bit 30 goes from 0 to 1 on a config write, status bit 30 sets. If it goes from 1 to 0, status bit 30 clears. No other status bit is ever 1.
- R7: The refresh timer stores data ANDed with 0x3FF80000. ECC config stores data ANDed with 0x00F00000. Each bank config stores data ANDed with 0xFFDEE001. The error address stores all 32 bits.
- R8: The idle timer stores written bits 31:27 and always reads 0x07C00000 in bits 26:0.
- R9: ECC status (0x98) stores data ANDed with 0xFFF0F000. The ecc_irq output is registered. From the cycle after a write it is high exactly when the stored value is non-zero.
- R10: rd_data changes only on the clock edge that ends a read access, and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access strobe, one cycle per access |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_port | input | 10 | Bus port number (0x010 index, 0x011 data) |
| acc_wdata | input | 32 | Write data |
| err0_set | input | 32 | Error bits ORed into error status 0 |
| err1_set | input | 32 | Error bits ORed into error status 1 |
| rd_data | output | 32 | Registered read data |
| ecc_irq | output | 1 | Level interrupt, ECC status non-zero |

## Verification
The assertions assume three things about the inputs:
- Reset is held for at least one edge before any access.
- `acc_write` is meaningful only while `acc_valid` is high.
- A data-port access always refers to the index held before that edge, so an index write and a data access never share a cycle.

The bench keeps within these limits:
- It issues at most one access per cycle, with strobes driven on falling edges.
- It writes the index in its own access before each data access.
- It drives the error-set vectors only as single-cycle pulses, mixed with random reads and writes over every mapped index and a set of unmapped ones.

// File: rtl/memctl_cfg_pkg.sv
package memctl_cfg_pkg;

    localparam int DW = 32;
    localparam int PW = 10;

    localparam logic [PW-1:0] PORT_INDEX = 10'h010;
    localparam logic [PW-1:0] PORT_DATA  = 10'h011;

    // internal register indices
    localparam logic [DW-1:0] IX_ERR0  = 32'h00;
    localparam logic [DW-1:0] IX_ERR1  = 32'h08;
    localparam logic [DW-1:0] IX_EADR  = 32'h10;
    localparam logic [DW-1:0] IX_CFG   = 32'h20;
    localparam logic [DW-1:0] IX_STAT  = 32'h24;
    localparam logic [DW-1:0] IX_RFSH  = 32'h30;
    localparam logic [DW-1:0] IX_IDLE  = 32'h34;
    localparam logic [DW-1:0] IX_BANK0 = 32'h40;
    localparam logic [DW-1:0] IX_TIME  = 32'h80;
    localparam logic [DW-1:0] IX_ECFG  = 32'h94;
    localparam logic [DW-1:0] IX_EST   = 32'h98;

    // write masks
    localparam logic [DW-1:0] MSK_CFG  = 32'hFFE0_0000;
    localparam logic [DW-1:0] MSK_RFSH = 32'h3FF8_0000;
    localparam logic [DW-1:0] MSK_IDLE = 32'hF800_0000;
    localparam logic [DW-1:0] FRC_IDLE = 32'h07C0_0000;
    localparam logic [DW-1:0] MSK_ECFG = 32'h00F0_0000;
    localparam logic [DW-1:0] MSK_EST  = 32'hFFF0_F000;
    localparam logic [DW-1:0] MSK_BANK = 32'hFFDE_E001;

    // reset values
    localparam logic [DW-1:0] RST_CFG  = 32'h0080_0000;
    localparam logic [DW-1:0] RST_RFSH = 32'h05F0_0000;
    localparam logic [DW-1:0] RST_IDLE = 32'h07C0_0000;

    localparam logic [DW-1:0] ALL_ONES = '1;

    localparam int EN_BIT = 31;
    localparam int SR_BIT = 30;

    typedef enum logic [3:0] {
        RID_ERR0, RID_ERR1, RID_EADR, RID_CFG, RID_STAT, RID_RFSH,
        RID_IDLE, RID_BANK, RID_ECFG, RID_EST, RID_NONE
    } reg_id_e;

    typedef struct packed {
        reg_id_e    id;
        logic [1:0] bank;
    } reg_sel_t;

    function automatic reg_sel_t decode_index(input logic [DW-1:0] ix, input int nbanks);
        reg_sel_t r;
        r.id   = RID_NONE;
        r.bank = 2'd0;
        unique case (ix)
            IX_ERR0: r.id = RID_ERR0;
            IX_ERR1: r.id = RID_ERR1;
            IX_EADR: r.id = RID_EADR;
            IX_CFG:  r.id = RID_CFG;
            IX_STAT: r.id = RID_STAT;
            IX_RFSH: r.id = RID_RFSH;
            IX_IDLE: r.id = RID_IDLE;
            IX_ECFG: r.id = RID_ECFG;
            IX_EST:  r.id = RID_EST;
            default: begin
                if (ix >= IX_BANK0 && ix < IX_BANK0 + DW'(4 * nbanks) && ix[1:0] == 2'b00) begin
                    r.id   = RID_BANK;
                    r.bank = ix[3:2];
                end
            end
        endcase
        return r;
    endfunction

endpackage

// File: rtl/cfg_masked_reg.sv
module cfg_masked_reg
    import memctl_cfg_pkg::*;
#(
    parameter logic [DW-1:0] MASK  = '1,
    parameter logic [DW-1:0] FORCE = '0,
    parameter logic [DW-1:0] RSTV  = '0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= RSTV;
        end else if (we) begin
            q <= (wdata & MASK) | FORCE;
        end
    end
endmodule

// File: rtl/cfg_w1c_reg.sv
module cfg_w1c_reg
    import memctl_cfg_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] set_bits,
    output logic [DW-1:0] q
);
    logic [DW-1:0] clr_bits;

    assign clr_bits = we ? wdata : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= (q & ~clr_bits) | set_bits;
        end
    end
endmodule

// File: rtl/cfg_ctrl_status.sv
module cfg_ctrl_status
    import memctl_cfg_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_we,
    input  logic          est_we,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] cfg_q,
    output logic [DW-1:0] stat_q,
    output logic [DW-1:0] est_q,
    output logic          irq_q
);
    logic [DW-1:0] cfg_new;
    logic [DW-1:0] est_new;
    logic          st_en_q;
    logic          st_sr_q;

    assign cfg_new = wdata & MSK_CFG;
    assign est_new = wdata & MSK_EST;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q   <= RST_CFG;
            st_en_q <= 1'b0;
            st_sr_q <= 1'b0;
        end else if (cfg_we) begin
            cfg_q <= cfg_new;
            if (!cfg_q[EN_BIT] && cfg_new[EN_BIT]) begin
                st_en_q <= 1'b0;
            end else if (cfg_q[EN_BIT] && !cfg_new[EN_BIT]) begin
                st_en_q <= 1'b1;
            end
            if (!cfg_q[SR_BIT] && cfg_new[SR_BIT]) begin
                st_sr_q <= 1'b1;
            end else if (cfg_q[SR_BIT] && !cfg_new[SR_BIT]) begin
                st_sr_q <= 1'b0;
            end
        end
    end

    always_comb begin
        stat_q         = '0;
        stat_q[EN_BIT] = st_en_q;
        stat_q[SR_BIT] = st_sr_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            est_q <= '0;
            irq_q <= 1'b0;
        end else if (est_we) begin
            est_q <= est_new;
            irq_q <= (est_new != '0);
        end
    end
endmodule

// File: rtl/memctl_cfg_regs.sv
module memctl_cfg_regs
    import memctl_cfg_pkg::*;
#(
    parameter int NUM_BANKS = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          acc_valid,
    input  logic          acc_write,
    input  logic [PW-1:0] acc_port,
    input  logic [DW-1:0] acc_wdata,
    input  logic [DW-1:0] err0_set,
    input  logic [DW-1:0] err1_set,
    output logic [DW-1:0] rd_data,
    output logic          ecc_irq
);
    localparam int NB = (NUM_BANKS > 4) ? 4 : NUM_BANKS;

    logic [DW-1:0] idx_q;
    reg_sel_t      sel;
    logic          wr_idx, wr_dat, rd_acc;

    logic [DW-1:0] err0_q, err1_q, eadr_q, rfsh_q, idle_q, ecfg_q;
    logic [DW-1:0] cfg_q, stat_q, est_q;
    logic [DW-1:0] bank_q [NB];
    logic [DW-1:0] dat_mux;

    assign sel    = decode_index(idx_q, NB);
    assign wr_idx = acc_valid && acc_write && acc_port == PORT_INDEX;
    assign wr_dat = acc_valid && acc_write && acc_port == PORT_DATA;
    assign rd_acc = acc_valid && !acc_write;

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q <= '0;
        end else if (wr_idx) begin
            idx_q <= acc_wdata;
        end
    end

    cfg_w1c_reg u_err0 (
        .clk(clk), .rst(rst), .we(wr_dat && sel.id == RID_ERR0),
        .wdata(acc_wdata), .set_bits(err0_set), .q(err0_q)
    );

    cfg_w1c_reg u_err1 (
        .clk(clk), .rst(rst), .we(wr_dat && sel.id == RID_ERR1),
        .wdata(acc_wdata), .set_bits(err1_set), .q(err1_q)
    );

    cfg_masked_reg #(.MASK('1), .FORCE('0), .RSTV('0)) u_eadr (
        .clk(clk), .rst(rst), .we(wr_dat && sel.id == RID_EADR),
        .wdata(acc_wdata), .q(eadr_q)
    );

    cfg_masked_reg #(.MASK(MSK_RFSH), .FORCE('0), .RSTV(RST_RFSH)) u_rfsh (
        .clk(clk), .rst(rst), .we(wr_dat && sel.id == RID_RFSH),
        .wdata(acc_wdata), .q(rfsh_q)
    );

    cfg_masked_reg #(.MASK(MSK_IDLE), .FORCE(FRC_IDLE), .RSTV(RST_IDLE)) u_idle (
        .clk(clk), .rst(rst), .we(wr_dat && sel.id == RID_IDLE),
        .wdata(acc_wdata), .q(idle_q)
    );

    cfg_masked_reg #(.MASK(MSK_ECFG), .FORCE('0), .RSTV('0)) u_ecfg (
        .clk(clk), .rst(rst), .we(wr_dat && sel.id == RID_ECFG),
        .wdata(acc_wdata), .q(ecfg_q)
    );

    for (genvar b = 0; b < NB; b++) begin : g_bank
        cfg_masked_reg #(.MASK(MSK_BANK), .FORCE('0), .RSTV('0)) u_bank (
            .clk(clk), .rst(rst),
            .we(wr_dat && sel.id == RID_BANK && sel.bank == 2'(b)),
            .wdata(acc_wdata), .q(bank_q[b])
        );
    end

    cfg_ctrl_status u_ctrl (
        .clk(clk), .rst(rst),
        .cfg_we(wr_dat && sel.id == RID_CFG),
        .est_we(wr_dat && sel.id == RID_EST),
        .wdata(acc_wdata),
        .cfg_q(cfg_q), .stat_q(stat_q), .est_q(est_q), .irq_q(ecc_irq)
    );

    always_comb begin
        dat_mux = ALL_ONES;
        unique case (sel.id)
            RID_ERR0: dat_mux = err0_q;
            RID_ERR1: dat_mux = err1_q;
            RID_EADR: dat_mux = eadr_q;
            RID_CFG:  dat_mux = cfg_q;
            RID_STAT: dat_mux = stat_q;
            RID_RFSH: dat_mux = rfsh_q;
            RID_IDLE: dat_mux = idle_q;
            RID_BANK: dat_mux = bank_q[sel.bank];
            RID_ECFG: dat_mux = ecfg_q;
            RID_EST:  dat_mux = est_q;
            default:  dat_mux = ALL_ONES;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
        end else if (rd_acc) begin
            if (acc_port == PORT_INDEX) begin
                rd_data <= idx_q;
            end else if (acc_port == PORT_DATA) begin
                rd_data <= dat_mux;
            end else begin
                rd_data <= '0;
            end
        end
    end
endmodule

// File: rtl/memctl_cfg_regs_chk.sv
module memctl_cfg_regs_chk
    import memctl_cfg_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic          acc_valid,
    input logic          acc_write,
    input logic [PW-1:0] acc_port,
    input logic [DW-1:0] acc_wdata,
    input logic [DW-1:0] idx_q,
    input logic [DW-1:0] err0_q,
    input logic [DW-1:0] stat_q,
    input logic [DW-1:0] idle_q,
    input logic [DW-1:0] rd_data,
    input logic          ecc_irq
);
    logic dwr;
    assign dwr = acc_valid && acc_write && acc_port == PORT_DATA;

    // R9
    est_irq_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (dwr && idx_q == IX_EST && (acc_wdata & MSK_EST) != '0) |=> ecc_irq);

    // R9
    est_irq_fall_chk: assert property (@(posedge clk) disable iff (rst)
        (dwr && idx_q == IX_EST && (acc_wdata & MSK_EST) == '0) |=> !ecc_irq);

    // R4
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        !(dwr && idx_q == IX_ERR0) |=> ((err0_q & $past(err0_q)) == $past(err0_q)));

    // R3
    stat_ro_chk: assert property (@(posedge clk) disable iff (rst)
        (dwr && idx_q == IX_STAT) |=> $stable(stat_q));

    // R5
    en_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (dwr && idx_q == IX_CFG && acc_wdata[EN_BIT]) |=> !stat_q[EN_BIT]);

    // R6
    stat_bits_chk: assert property (@(posedge clk) disable iff (rst)
        (stat_q & ~(32'hC000_0000)) == '0);

    // R8
    idle_low_chk: assert property (@(posedge clk) disable iff (rst)
        idle_q[26:0] == FRC_IDLE[26:0]);

    // R10
    rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(acc_valid && !acc_write) |=> $stable(rd_data));
endmodule

bind memctl_cfg_regs memctl_cfg_regs_chk u_chk (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_port(acc_port), .acc_wdata(acc_wdata), .idx_q(idx_q),
    .err0_q(err0_q), .stat_q(stat_q), .idle_q(idle_q),
    .rd_data(rd_data), .ecc_irq(ecc_irq)
);

// File: tb/tb_memctl_cfg_regs.sv
module tb_memctl_cfg_regs;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [9:0]  acc_port = '0;
    logic [31:0] acc_wdata = '0;
    logic [31:0] err0_set = '0;
    logic [31:0] err1_set = '0;
    logic [31:0] rd_data;
    logic        ecc_irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // bench model
    logic [31:0] m_idx, m_err0, m_err1, m_eadr, m_cfg, m_rfsh, m_idle, m_ecfg, m_est;
    logic        m_sen, m_ssr;
    logic [31:0] m_bank [4];

    always #5 clk = ~clk;

    memctl_cfg_regs dut (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_port(acc_port), .acc_wdata(acc_wdata), .err0_set(err0_set),
        .err1_set(err1_set), .rd_data(rd_data), .ecc_irq(ecc_irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        m_idx = 0; m_err0 = 0; m_err1 = 0; m_eadr = 0;
        m_cfg = 32'h0080_0000; m_rfsh = 32'h05F0_0000; m_idle = 32'h07C0_0000;
        m_ecfg = 0; m_est = 0; m_sen = 0; m_ssr = 0;
        for (int i = 0; i < 4; i++) m_bank[i] = 0;
    endtask

    function automatic logic [31:0] exp_data(input logic [31:0] ix);
        case (ix)
            32'h00: return m_err0;
            32'h08: return m_err1;
            32'h10: return m_eadr;
            32'h20: return m_cfg;
            32'h24: return {m_sen, m_ssr, 30'd0};
            32'h30: return m_rfsh;
            32'h34: return m_idle;
            32'h40: return m_bank[0];
            32'h44: return m_bank[1];
            32'h48: return m_bank[2];
            32'h4C: return m_bank[3];
            32'h94: return m_ecfg;
            32'h98: return m_est;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

    task automatic model_data_write(input logic [31:0] ix, input logic [31:0] v);
        logic [31:0] c;
        case (ix)
            32'h00: m_err0 = m_err0 & ~v;
            32'h08: m_err1 = m_err1 & ~v;
            32'h10: m_eadr = v;
            32'h20: begin
                c = v & 32'hFFE0_0000;
                if (!m_cfg[31] && c[31]) m_sen = 0;
                else if (m_cfg[31] && !c[31]) m_sen = 1;
                if (!m_cfg[30] && c[30]) m_ssr = 1;
                else if (m_cfg[30] && !c[30]) m_ssr = 0;
                m_cfg = c;
            end
            32'h30: m_rfsh = v & 32'h3FF8_0000;
            32'h34: m_idle = (v & 32'hF800_0000) | 32'h07C0_0000;
            32'h40: m_bank[0] = v & 32'hFFDE_E001;
            32'h44: m_bank[1] = v & 32'hFFDE_E001;
            32'h48: m_bank[2] = v & 32'hFFDE_E001;
            32'h4C: m_bank[3] = v & 32'hFFDE_E001;
            32'h94: m_ecfg = v & 32'h00F0_0000;
            32'h98: m_est = v & 32'hFFF0_F000;
            default: ;
        endcase
    endtask

    // one access, inputs driven on the falling edge, results sampled on the next one
    task automatic access(input string req, input logic [9:0] port, input bit wr,
                          input logic [31:0] v, input logic [31:0] s0, input logic [31:0] s1);
        logic [31:0] exp;
        exp = (port == 10'h010) ? m_idx : (port == 10'h011) ? exp_data(m_idx) : 32'h0;
        acc_valid = 1'b1; acc_write = wr; acc_port = port; acc_wdata = v;
        err0_set = s0; err1_set = s1;
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0; err0_set = 0; err1_set = 0;
        if (wr) begin
            if (port == 10'h010) m_idx = v;
            else if (port == 10'h011) model_data_write(m_idx, v);
        end
        m_err0 = m_err0 | s0;
        m_err1 = m_err1 | s1;
        if (!wr) check(req, rd_data, exp);
        else if (port == 10'h011 && m_idx == 32'h98) check({req, " irq"}, {31'd0, ecc_irq}, {31'd0, m_est != 0});
    endtask

    task automatic rd_reg(input string req, input logic [31:0] ix);
        access(req, 10'h010, 1, ix, 0, 0);
        access(req, 10'h011, 0, 0, 0, 0);
    endtask

    task automatic wr_reg(input string req, input logic [31:0] ix, input logic [31:0] v);
        access(req, 10'h010, 1, ix, 0, 0);
        access(req, 10'h011, 1, v, 0, 0);
    endtask

    function automatic logic [31:0] pick_index(input int k);
        case (k)
            0: return 32'h00;  1: return 32'h08;  2: return 32'h10;  3: return 32'h20;
            4: return 32'h24;  5: return 32'h30;  6: return 32'h34;  7: return 32'h40;
            8: return 32'h44;  9: return 32'h48; 10: return 32'h4C; 11: return 32'h80;
            12: return 32'h94; 13: return 32'h98; 14: return 32'h04; 15: return 32'h50;
            16: return 32'h42; default: return 32'h1_0000;
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'd20240517);
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R2 reset values
        for (int k = 0; k < 14; k++) rd_reg("R2", pick_index(k));
        check("R2 irq", {31'd0, ecc_irq}, 32'd0);

        // R1 index port and foreign ports
        access("R1", 10'h010, 1, 32'hDEAD_BEEF, 0, 0);
        access("R1", 10'h010, 0, 0, 0, 0);
        access("R1", 10'h012, 0, 0, 0, 0);
        access("R10", 10'h012, 1, 32'h1234, 0, 0);
        check("R10 hold", rd_data, 32'h0);

        // R3 unmapped, timing and status writes
        wr_reg("R3", 32'h80, 32'hFFFF_FFFF);
        rd_reg("R3", 32'h80);
        wr_reg("R3", 32'h24, 32'hFFFF_FFFF);
        rd_reg("R3", 32'h24);
        wr_reg("R3", 32'h50, 32'h1234_5678);
        rd_reg("R3", 32'h50);

        // R4 error set, clear, set-wins
        access("R4", 10'h010, 1, 32'h00, 32'hF0F0_00FF, 32'h0000_8001);
        rd_reg("R4", 32'h00);
        rd_reg("R4", 32'h08);
        access("R4", 10'h011, 0, 0, 0, 0);
        access("R4", 10'h010, 1, 32'h00, 0, 0);
        access("R4", 10'h011, 1, 32'hF000_0001, 32'h0000_0001, 0);
        rd_reg("R4", 32'h00);

        // R5/R6 config edges
        wr_reg("R5", 32'h20, 32'hC01F_FFFF);
        rd_reg("R5", 32'h20);
        rd_reg("R6", 32'h24);
        wr_reg("R5", 32'h20, 32'h0000_0000);
        rd_reg("R5", 32'h24);
        wr_reg("R6", 32'h20, 32'h4000_0000);
        rd_reg("R6", 32'h24);

        // R7/R8 masks
        wr_reg("R7", 32'h30, 32'hFFFF_FFFF); rd_reg("R7", 32'h30);
        wr_reg("R7", 32'h94, 32'hFFFF_FFFF); rd_reg("R7", 32'h94);
        wr_reg("R7", 32'h4C, 32'hFFFF_FFFF); rd_reg("R7", 32'h4C);
        wr_reg("R7", 32'h10, 32'hA5A5_5A5A); rd_reg("R7", 32'h10);
        wr_reg("R8", 32'h34, 32'h0000_0000); rd_reg("R8", 32'h34);
        wr_reg("R8", 32'h34, 32'hFFFF_FFFF); rd_reg("R8", 32'h34);

        // R9 irq level
        wr_reg("R9", 32'h98, 32'h000F_0FFF);
        wr_reg("R9", 32'h98, 32'h0000_1000);
        rd_reg("R9", 32'h98);
        wr_reg("R9", 32'h98, 32'h0000_0000);

        // random mix
        for (int n = 0; n < 1500; n++) begin
            int op;
            logic [31:0] v, s0, s1;
            op = $urandom % 8;
            v  = $urandom;
            s0 = ($urandom % 4 == 0) ? ($urandom & $urandom) : 32'h0;
            s1 = ($urandom % 4 == 0) ? ($urandom & $urandom) : 32'h0;
            if (op < 2) begin
                access("R1", 10'h010, 1, pick_index($urandom % 18), s0, s1);
            end else if (op < 5) begin
                access("R10", 10'h011, 0, 0, s0, s1);
            end else if (op < 7) begin
                access("R7", 10'h011, 1, ($urandom % 3 == 0) ? 32'h0 : v, s0, s1);
            end else begin
                access("R1", ($urandom % 2) ? 10'h010 : 10'h013, 0, 0, s0, s1);
            end
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule